// File: doc/BRIEF.md
# Comma Detector and Word Aligner

This receive-side block sits right after a deserializer. The deserializer hands it 10-bit words whose boundaries bear no fixed relation to the character boundaries the transmitter used. On every valid word the block joins the word to the one before it and forms a 20-bit window. It tests all ten bit offsets of that window against a programmable alignment pattern. The pattern is compared through a mask, and its bitwise complement can optionally be accepted as well. One setting therefore serves an 8b/10b comma in either running disparity, a framing byte pair or a marker chosen for a custom backplane.

When realignment is enabled, a match at an offset different from the one in force moves the word boundary to the new offset. The block pulses a flag with the first word cut at that boundary. With realignment disabled, the boundary it holds does not move. Three matches in a row at the held boundary, with no boundary move between them, raise a sync flag. A programmable number of code-group error pulses from a later decoding stage lowers the flag again.

Top module: `comma_word_aligner`

## Requirements
- R1: While reset is held and on the first cycle after it, out_valid, sync_ok and boundary_change are low, and the held offset is 0.
- R2: The window is {in_word, previous valid word}, bit 0 earliest on the line. The candidate at offset k (0..9) is window bits k+9..k. It matches when it equals pat_value on every bit where pat_mask is 1. When pol_both is 1, a candidate equal to ~pat_value on those bits also matches. When several offsets match, the lowest one wins.
- R3: One cycle after a valid input, out_valid is 1 and out_word holds the candidate at the offset in force. That offset is the new one when the same input moves the boundary.
- R4: With realign_en high, a match at an offset other than the held one moves the held offset there. boundary_change is then high for exactly the cycle that carries the first word at the new offset.
- R5: With realign_en low, the held offset never changes and boundary_change stays low, whatever matches arrive.
- R6: A valid input that matches at the held offset advances a match count, which saturates at 3. A boundary move restarts the count at 1. sync_ok goes high in the same cycle the count reaches 3.
- R7: While sync_ok is high, each code_err pulse is counted. When the count reaches loss_limit, sync_ok falls on the next cycle; a loss_limit of 0 acts as 1. The error count and the match count then clear.
- R8: When a loss of sync and a match at the held offset fall in the same cycle, the loss wins. The match count becomes 0, so three further matches are needed to regain sync.
- R9: A cycle with in_valid low leaves the window history, the held offset and the match count unchanged and gives out_valid low. code_err pulses are still counted in such a cycle.
- R10: A boundary move clears sync_ok in the same cycle that boundary_change is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies in_word |
| in_word | input | 10 | Deserialized word, bit 0 received first |
| pat_value | input | 10 | Alignment pattern, bit 0 first |
| pat_mask | input | 10 | 1 = bit takes part in the comparison |
| pol_both | input | 1 | Also accept the complemented pattern |
| realign_en | input | 1 | Allows the boundary to move |
| code_err | input | 1 | One pulse per code-group error |
| loss_limit | input | 4 | Errors that drop sync (0 treated as 1) |
| out_valid | output | 1 | out_word is valid |
| out_word | output | 10 | Word at the aligned boundary |
| sync_ok | output | 1 | Alignment is trusted |
| boundary_change | output | 1 | First word after a boundary move |

## Verification
Two functions can meet in one cycle: the error pulse that ends sync, and a pattern match at the held offset that would advance the match count. The bench synchronizes and sets loss_limit to 1. It then drives the word that completes a pattern match together with an error pulse. After that it sends exactly two more matches and requires sync_ok to stay low, then sends a third and requires sync_ok to rise. Random phases also place boundary moves and error pulses side by side, and each such cycle is judged against the bench's reference model.

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
  parameter int W = 10,
  parameter int SYNC_MATCHES = 3,
  parameter int LOSSW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [W-1:0]     in_word,
  input  logic [W-1:0]     pat_value,
  input  logic [W-1:0]     pat_mask,
  input  logic             pol_both,
  input  logic             realign_en,
  input  logic             code_err,
  input  logic [LOSSW-1:0] loss_limit,
  output logic             out_valid,
  output logic [W-1:0]     out_word,
  output logic             sync_ok,
  output logic             boundary_change
);
  localparam int OFFW = $clog2(W);
  localparam int CNTW = $clog2(SYNC_MATCHES + 1);

  logic [W-1:0]     prev_q;
  logic [OFFW-1:0]  off_q;
  logic [CNTW-1:0]  cnt_q, cnt_n;
  logic [LOSSW:0]   err_q, err_n;
  logic             sync_n;
  logic [2*W-1:0]   win;
  logic [W-1:0]     hit;
  logic [OFFW-1:0]  first_off, sel_off;
  logic             move, loss;
  logic [2*W-1:0]   shifted;
  logic [LOSSW:0]   lim;

  assign win = {in_word, prev_q};

  for (genvar k = 0; k < W; k++) begin : g_cmp
    logic [W-1:0] cand;
    assign cand   = win[k +: W];
    assign hit[k] = (((cand ^ pat_value) & pat_mask) == '0) ||
                    (pol_both && (((cand ^ ~pat_value) & pat_mask) == '0));
  end

  always_comb begin
    first_off = '0;
    for (int k = W - 1; k >= 0; k--)
      if (hit[k]) first_off = OFFW'(k);
  end

  assign move    = in_valid && realign_en && (|hit) && (first_off != off_q);
  assign sel_off = move ? first_off : off_q;
  assign shifted = win >> sel_off;
  assign lim     = (loss_limit == '0) ? (LOSSW+1)'(1) : {1'b0, loss_limit};
  assign loss    = sync_ok && code_err && ((err_q + 1'b1) >= lim);

  always_comb begin
    cnt_n  = cnt_q;
    sync_n = sync_ok;
    err_n  = err_q;
    if (in_valid && hit[sel_off]) begin
      if (move) cnt_n = CNTW'(1);
      else if (cnt_q < CNTW'(SYNC_MATCHES)) cnt_n = cnt_q + 1'b1;
    end
    if (move) sync_n = 1'b0;
    else if (cnt_n == CNTW'(SYNC_MATCHES)) sync_n = 1'b1;
    if (sync_ok && code_err) err_n = err_q + 1'b1;
    if (!sync_n) err_n = '0;
    if (loss) begin
      sync_n = 1'b0;
      cnt_n  = '0;
      err_n  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q          <= '0;
      off_q           <= '0;
      cnt_q           <= '0;
      err_q           <= '0;
      sync_ok         <= 1'b0;
      out_valid       <= 1'b0;
      out_word        <= '0;
      boundary_change <= 1'b0;
    end else begin
      out_valid       <= in_valid;
      boundary_change <= move;
      cnt_q           <= cnt_n;
      sync_ok         <= sync_n;
      err_q           <= err_n;
      if (in_valid) begin
        prev_q   <= in_word;
        off_q    <= sel_off;
        out_word <= shifted[W-1:0];
      end
    end
  end

  a_r4_pulse_matches_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_change |->
      ((((out_word ^ $past(pat_value)) & $past(pat_mask)) == '0) ||
       ($past(pol_both) && (((out_word ^ ~$past(pat_value)) & $past(pat_mask)) == '0))));

  a_r5_no_move_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_change |-> $past(realign_en) && $past(in_valid));

  a_r9_valid_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  a_r10_move_drops_sync: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_change |-> !sync_ok);

  a_r6_rise_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_ok) |-> $past(in_valid) && !boundary_change);

  a_r7_fall_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_ok) |-> boundary_change || $past(code_err));
endmodule

// File: tb/tb_comma_word_aligner.sv
module tb_comma_word_aligner;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, pol_both = 1, realign_en = 1, code_err = 0;
  logic [9:0] in_word = 0, pat_value = 10'h17C, pat_mask = 10'h07F;
  logic [3:0] loss_limit = 4'd2;
  logic out_valid, sync_ok, boundary_change;
  logic [9:0] out_word;

  always #4 clk = ~clk;

  comma_word_aligner dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .pat_value(pat_value), .pat_mask(pat_mask), .pol_both(pol_both),
    .realign_en(realign_en), .code_err(code_err), .loss_limit(loss_limit),
    .out_valid(out_valid), .out_word(out_word), .sync_ok(sync_ok),
    .boundary_change(boundary_change));

  localparam logic [9:0] CM = 10'h17C, CP = 10'h283, DT = 10'h155;

  int checks = 0, errors = 0, bc_seen = 0;
  logic [9:0] m_prev = 0;
  int m_off = 0, m_cnt = 0, m_err = 0;
  logic m_sync = 0;
  logic [63:0] lbuf = 0;
  int nb = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic hits(logic [19:0] w, int k);
    logic [9:0] c = w[k +: 10];
    return (((c ^ pat_value) & pat_mask) == 0) ||
           (pol_both && (((c ^ ~pat_value) & pat_mask) == 0));
  endfunction

  task automatic cycle(input logic v, input logic [9:0] w, input logic e);
    logic [19:0] win = {w, m_prev};
    int first = -1, sel, lim;
    logic mv = 0, ex_sync, lossx;
    logic [9:0] ex_word;
    for (int k = 9; k >= 0; k--) if (hits(win, k)) first = k;
    mv  = v && realign_en && first >= 0 && first != m_off;
    sel = mv ? first : m_off;
    ex_word = win[sel +: 10];
    lim = (loss_limit == 0) ? 1 : loss_limit;
    lossx = m_sync && e && (m_err + 1 >= lim);
    ex_sync = m_sync;
    if (v && hits(win, sel)) m_cnt = mv ? 1 : (m_cnt < 3 ? m_cnt + 1 : 3);
    if (mv) ex_sync = 0; else if (m_cnt == 3) ex_sync = 1;
    if (m_sync && e) m_err++;
    if (!ex_sync) m_err = 0;
    if (lossx) begin ex_sync = 0; m_cnt = 0; m_err = 0; end
    if (v) begin m_prev = w; m_off = sel; end
    m_sync = ex_sync;
    in_valid = v; in_word = w; code_err = e;
    @(posedge clk); @(negedge clk);
    in_valid = 0; code_err = 0;
    if (boundary_change) bc_seen++;
    chk(out_valid == v, "R9", out_valid, v);
    if (v) chk(out_word == ex_word, "R3", out_word, ex_word);
    chk(boundary_change == mv, "R4", boundary_change, mv);
    chk(sync_ok == ex_sync, "R6", sync_ok, ex_sync);
    if (boundary_change) chk(!sync_ok, "R10", sync_ok, 0);
  endtask

  task automatic push_bits(input logic [9:0] b, input int n);
    for (int i = 0; i < n; i++) lbuf[nb + i] = b[i];
    nb += n;
    while (nb >= 10) begin
      logic [9:0] w = lbuf[9:0];
      lbuf = lbuf >> 10; nb -= 10;
      cycle(1, w, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!out_valid && !sync_ok && !boundary_change, "R1", {out_valid, sync_ok, boundary_change}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid && !sync_ok && !boundary_change, "R1", {out_valid, sync_ok, boundary_change}, 0);

    // R4 R6: slip of 3 bits, commas and data
    push_bits(10'h2A5, 3);
    for (int i = 0; i < 4; i++) begin push_bits(CM, 10); push_bits(DT, 10); end
    chk(bc_seen == 1, "R4", bc_seen, 1);
    chk(sync_ok == 1, "R6", sync_ok, 1);

    // R5: new slip with realignment disabled
    realign_en = 0; bc_seen = 0;
    push_bits(10'h000, 4);
    for (int i = 0; i < 4; i++) begin push_bits(CM, 10); push_bits(DT, 10); end
    chk(bc_seen == 0, "R5", bc_seen, 0);
    chk(sync_ok == 1, "R5", sync_ok, 1);

    // R7 with R9: errors on idle cycles
    loss_limit = 2;
    cycle(0, 0, 1);
    chk(sync_ok == 1, "R7", sync_ok, 1);
    cycle(0, 0, 1);
    chk(sync_ok == 0, "R7", sync_ok, 0);

    // direct aligned words, realignment back on
    realign_en = 1; nb = 0; lbuf = 0;
    for (int i = 0; i < 5; i++) begin cycle(1, CM, 0); cycle(1, DT, 0); end
    chk(sync_ok == 1, "R6", sync_ok, 1);

    // R8: loss and match in the same cycle
    loss_limit = 1;
    cycle(1, CM, 0);
    cycle(1, DT, 1);
    chk(sync_ok == 0, "R8", sync_ok, 0);
    cycle(1, CM, 0); cycle(1, DT, 0); cycle(1, CM, 0); cycle(1, DT, 0);
    chk(sync_ok == 0, "R8", sync_ok, 0);
    cycle(1, CM, 0); cycle(1, DT, 0);
    chk(sync_ok == 1, "R8", sync_ok, 1);

    // R7: limit 0 acts as 1
    loss_limit = 0;
    cycle(0, 0, 1);
    chk(sync_ok == 0, "R7", sync_ok, 0);

    // R2: complemented pattern only with pol_both
    pol_both = 0;
    for (int i = 0; i < 4; i++) begin cycle(1, CP, 0); cycle(1, DT, 0); end
    chk(sync_ok == 0, "R2", sync_ok, 0);
    pol_both = 1;
    for (int i = 0; i < 4; i++) begin cycle(1, CP, 0); cycle(1, DT, 0); end
    chk(sync_ok == 1, "R2", sync_ok, 1);

    // random phase
    loss_limit = 3;
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 15);
      realign_en = ($urandom_range(0, 7) != 0);
      if (r < 4) cycle(1, ($urandom_range(0, 1) != 0) ? CM : CP, $urandom_range(0, 9) == 0);
      else if (r < 6) cycle(0, 10'($urandom), $urandom_range(0, 3) == 0);
      else if (r == 6) cycle(1, 10'($urandom), 1);
      else cycle(1, ($urandom_range(0, 2) == 0) ? 10'($urandom) : DT, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule